// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block produces one pulse-width-modulated output from a 256-step period. Its counting clock is one of two clock enables, a slow one or the system one, picked by a configuration bit. A power-of-two prescaler divides the picked clock. An 8-bit counter then sweeps 0..255 once per period, and a compare value sets how many counts of each period the output is active. A polarity bit chooses whether the active level is high or low.

Software drives the block through a write-only register port. One word carries the compare value, the polarity and the prescaler code. A second word selects the counting clock. Two further addresses act as write-one strobes that start and stop the generator. A status pin reports whether the generator is running, and software polls it after each start or stop until it matches.

Settings written while the generator runs are staged and take effect only when the counter wraps. The output therefore never shows a shortened or stretched pulse.

Top module: `pwm8_prescaled`

## Requirements
- R1: A write to address 0 loads the configuration word. The compare value sits in bits 15:8, the polarity bit in bit 4 and the prescaler code in bits 2:0. All other bits are ignored.
- R2: With prescaler code p, one period lasts 256 × 2^p ticks of the selected counting clock, for p from 0 to 6.
- R3: A prescaler code of 7 behaves exactly like code 6.
- R4: With compare value N, the output is active for the first N counts of each period, so the duty is N/256. N = 0 never activates the output, and N = 255 keeps it active for all but the last count.
- R5: Polarity bit 1 makes the active level high. Polarity bit 0 inverts the output, so the active level is low.
- R6: Bit 0 of a write to address 1 selects the counting clock: 0 picks slow_ce and 1 picks sys_ce. After reset the slow clock is selected.
- R7: Writing 1 in bit 0 to address 2 sets pwm_running exactly 3 counting-clock ticks after the write. Writing 1 in bit 0 to address 3 clears it 3 ticks after the write. A strobe write with bit 0 = 0 has no effect.
- R8: While pwm_running is 0, the output holds its inactive level: low for polarity 1, high for polarity 0. Each start begins a fresh period at count 0. After reset the configuration is compare 0, polarity 1 and code 0, and the output is low.
- R9: A configuration write made while the generator runs leaves the current period unchanged. It takes effect at the next wrap from count 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | Slow counting-clock enable |
| sys_ce | input | 1 | System counting-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 config, 1 clock select, 2 start, 3 stop) |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | PWM output |
| pwm_running | output | 1 | Status: generator running |

## Verification
The bench builds the block with its default parameters: the prescaler cap at code 6 and a status latency of 3 ticks. With these defaults, every prescaler code can be measured over whole periods, up to 16384 cycles, within the run. The system enable is held high, so period and high time map directly onto clock cycles. One run paces the slow enable at every fourth cycle to show that the clock select matters. The start and stop latency is counted edge by edge. A compare write made mid-period is shown to leave the current pulse alone.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int CNT_W   = 8;
  localparam int PS_W    = 3;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;

  localparam logic [1:0] A_CFG   = 2'd0;
  localparam logic [1:0] A_CLK   = 2'd1;
  localparam logic [1:0] A_START = 2'd2;
  localparam logic [1:0] A_STOP  = 2'd3;

  typedef struct packed {
    logic [CNT_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } pwm_cfg_t;

  localparam pwm_cfg_t CFG_RST = '{cmp: '0, pol: 1'b1, ps: '0};
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int PS_CODE_MAX = 6,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output pwm_cfg_t          cfg_stage,
  output logic              clk_sel,
  output logic              start_stb,
  output logic              stop_stb
);
  localparam logic [PS_W-1:0] PS_CAP = PS_W'(PS_CODE_MAX);

  logic [PS_W-1:0] ps_in;

  always_comb begin
    ps_in = wr_data[PS_W-1:0];
    if (ps_in > PS_CAP) ps_in = PS_CAP;
  end

  assign start_stb = wr_en && (wr_addr == A_START) && wr_data[0];
  assign stop_stb  = wr_en && (wr_addr == A_STOP)  && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_stage <= CFG_RST;
      clk_sel   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_CFG) begin
        cfg_stage.cmp <= wr_data[CMP_LSB +: CNT_W];
        cfg_stage.pol <= wr_data[POL_BIT];
        cfg_stage.ps  <= ps_in;
      end
      if (wr_addr == A_CLK) clk_sel <= wr_data[0];
    end
  end
endmodule

// File: rtl/pwm8_handshake.sv
module pwm8_handshake #(
  parameter int STAT_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_stb,
  input  logic stop_stb,
  output logic running,
  output logic pend
);
  localparam int LW = (STAT_LAT < 2) ? 1 : $clog2(STAT_LAT);
  localparam logic [LW-1:0] LAST = LW'(STAT_LAT - 1);

  logic [LW-1:0] lat_q;
  logic          tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pend    <= 1'b0;
      tgt_q   <= 1'b0;
      lat_q   <= '0;
    end else if (start_stb || stop_stb) begin
      pend  <= 1'b1;
      tgt_q <= start_stb;
      lat_q <= '0;
    end else if (pend && tick) begin
      if (lat_q == LAST) begin
        running <= tgt_q;
        pend    <= 1'b0;
        lat_q   <= '0;
      end else begin
        lat_q <= lat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
  import pwm8_pkg::*;
#(
  parameter int PS_CODE_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  pwm_cfg_t         cfg_stage,
  output pwm_cfg_t         act_cfg,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             pwm_out
);
  localparam int PSC_W = (PS_CODE_MAX < 1) ? 1 : PS_CODE_MAX;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PSC_W-1:0] ps_q;
  logic [PSC_W-1:0] ps_mask;
  logic             step;
  logic             hit;

  always_comb ps_mask = {PSC_W{1'b1}} >> (PSC_W - int'(act_cfg.ps));

  assign step = tick && ((ps_q & ps_mask) == ps_mask);
  assign wrap = run && step && (cnt_q == CNT_MAX);
  assign hit  = cnt_q < act_cfg.cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q    <= '0;
      cnt_q   <= '0;
      act_cfg <= CFG_RST;
    end else begin
      if (!run) begin
        ps_q  <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        ps_q <= wrap ? '0 : ps_q + 1'b1;
        if (step) cnt_q <= cnt_q + 1'b1;
      end
      if (!run || wrap) act_cfg <= cfg_stage;
    end
  end

  assign pwm_out = run ? (act_cfg.pol ? hit : !hit) : !act_cfg.pol;
endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled
  import pwm8_pkg::*;
#(
  parameter int PS_CODE_MAX = 6,
  parameter int STAT_LAT    = 3,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_ce,
  input  logic              sys_ce,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              pwm_running
);
  pwm_cfg_t         cfg_stage;
  pwm_cfg_t         act_cfg;
  logic [CNT_W-1:0] cnt_q;
  logic             clk_sel, start_stb, stop_stb, tick, wrap, pend;

  assign tick = clk_sel ? sys_ce : slow_ce;

  pwm8_regs #(.PS_CODE_MAX(PS_CODE_MAX), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_stage(cfg_stage), .clk_sel(clk_sel),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  pwm8_handshake #(.STAT_LAT(STAT_LAT)) u_hs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_stb(start_stb),
    .stop_stb(stop_stb), .running(pwm_running), .pend(pend)
  );

  pwm8_core #(.PS_CODE_MAX(PS_CODE_MAX)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(pwm_running),
    .cfg_stage(cfg_stage), .act_cfg(act_cfg), .cnt_q(cnt_q),
    .wrap(wrap), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm8_prescaled_chk.sv
module pwm8_prescaled_chk
  import pwm8_pkg::*;
#(
  parameter int PS_CODE_MAX = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_out,
  input logic             running,
  input logic             pend,
  input logic             wrap,
  input pwm_cfg_t         act_cfg,
  input logic [CNT_W-1:0] cnt
);
  p_idle_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> cnt == '0);

  p_status_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(running) |-> $past(pend));

  p_ps_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_cfg.ps) <= PS_CODE_MAX);

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && !$past(wrap) |-> $stable(act_cfg));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1)));

  p_duty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && (act_cfg.cmp == '0) |-> pwm_out == !act_cfg.pol);
endmodule

bind pwm8_prescaled pwm8_prescaled_chk #(.PS_CODE_MAX(PS_CODE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .running(pwm_running),
  .pend(pend), .wrap(wrap), .act_cfg(act_cfg), .cnt(cnt_q)
);

// File: tb/pwm8_prescaled_tb.sv
module pwm8_prescaled_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_ce = 1'b0;
  logic        sys_ce = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, pwm_running;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  int div = 0;

  always #2.5 clk = ~clk;

  pwm8_prescaled u_dut (
    .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .sys_ce(sys_ce),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_running(pwm_running)
  );

  // slow clock enable: one pulse every fourth cycle
  always @(negedge clk) begin
    div = (div + 1) % 4;
    slow_ce = (div == 3);
  end

  // behavioural reference model
  int s_cmp, s_pol, s_ps, m_sel;
  int a_cmp, a_pol, a_ps;
  int m_ps, m_cnt, m_run, m_pend, m_tgt, m_lat;

  always @(posedge clk) begin
    int tick, mask, step, wrp, n_run, n_pend, n_tgt, n_lat, d;
    if (!rst_n) begin
      s_cmp = 0; s_pol = 1; s_ps = 0; m_sel = 0;
      a_cmp = 0; a_pol = 1; a_ps = 0;
      m_ps = 0; m_cnt = 0; m_run = 0; m_pend = 0; m_tgt = 0; m_lat = 0;
    end else begin
      tick = m_sel ? int'(sys_ce) : int'(slow_ce);
      mask = (1 << a_ps) - 1;
      step = tick && ((m_ps & mask) == mask);
      wrp  = m_run && step && (m_cnt == 255);
      n_run = m_run; n_pend = m_pend; n_tgt = m_tgt; n_lat = m_lat;
      if (wr_en && wr_addr >= 2 && wr_data[0]) begin
        n_pend = 1; n_tgt = (wr_addr == 2); n_lat = 0;
      end else if (m_pend && tick) begin
        if (m_lat == 2) begin n_run = m_tgt; n_pend = 0; n_lat = 0; end
        else n_lat = m_lat + 1;
      end
      if (!m_run || wrp) begin a_cmp = s_cmp; a_pol = s_pol; a_ps = s_ps; end
      if (!m_run) begin m_ps = 0; m_cnt = 0; end
      else if (tick) begin
        m_ps = wrp ? 0 : (m_ps + 1) % 64;
        if (step) m_cnt = (m_cnt + 1) % 256;
      end
      if (wr_en && wr_addr == 0) begin
        d = int'(wr_data);
        s_cmp = (d >> 8) & 255; s_pol = (d >> 4) & 1; s_ps = d & 7;
        if (s_ps > 6) s_ps = 6;
      end
      if (wr_en && wr_addr == 1) m_sel = wr_data[0];
      m_run = n_run; m_pend = n_pend; m_tgt = n_tgt; m_lat = n_lat;
    end
  end

  function automatic int exp_out();
    int hit;
    hit = (m_cnt < a_cmp);
    if (!m_run) return (a_pol == 0);
    return a_pol ? hit : !hit;
  endfunction

  // every-cycle comparison against the model (R2 R4 R5 R7 R8 R9)
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      checks++;
      if (int'(pwm_out) != exp_out() || int'(pwm_running) != m_run) begin
        fails++;
        $display("FAIL model R4/R7: out=%0d run=%0d expected out=%0d run=%0d",
                 pwm_out, pwm_running, exp_out(), m_run);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_run(int lvl);
    for (int i = 0; i < 4000 && int'(pwm_running) != lvl; i++) @(negedge clk);
  endtask

  // measure active count over one period and rise-to-rise period
  task automatic measure(string req, int p, int pol, int n, int code);
    int w, hi, t;
    bit act, prv;
    w = 256 << p;
    wr(0, (n << 8) | (pol << 4) | code);
    wr(2, 1);
    wait_run(1);
    hi = 0;
    for (int i = 0; i < w; i++) begin
      if (pwm_out == pol[0]) hi++;
      @(negedge clk);
    end
    check({req, " high time"}, hi, n << p);
    t = 0; prv = 1'b1; act = (pwm_out == pol[0]);
    for (int i = 0; i < 2 * w + 8; i++) begin
      @(negedge clk);
      t++;
      prv = act;
      act = (pwm_out == pol[0]);
      if (act && !prv) break;
    end
    check({req, " period"}, t, w);
    wr(3, 1);
    wait_run(0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int hi, seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset output low", pwm_out, 0);
    check("R8 reset not running", pwm_running, 0);
    cmp_on = 1;

    // R6: switch to the system clock
    wr(1, 1);

    // R7: start and stop latency, counted on sys_ce ticks
    wr(0, (128 << 8) | 16);
    wr(2, 0);
    repeat (6) @(negedge clk);
    check("R7 start bit0=0 ignored", pwm_running, 0);
    wr(2, 1);
    check("R7 start tick0", pwm_running, 0);
    @(negedge clk); check("R7 start tick1", pwm_running, 0);
    @(negedge clk); check("R7 start tick2", pwm_running, 0);
    @(negedge clk); check("R7 start tick3", pwm_running, 1);
    wr(3, 1);
    check("R7 stop tick0", pwm_running, 1);
    @(negedge clk); check("R7 stop tick1", pwm_running, 1);
    @(negedge clk); check("R7 stop tick2", pwm_running, 1);
    @(negedge clk); check("R7 stop tick3", pwm_running, 0);

    // R8: idle level follows polarity, including the inverted case
    wr(0, (200 << 8) | 0);
    repeat (3) @(negedge clk);
    check("R8 idle level pol0", pwm_out, 1);
    wr(0, (200 << 8) | 16);
    repeat (3) @(negedge clk);
    check("R8 idle level pol1", pwm_out, 0);

    // R1 R2 R4 R5: every prescaler code with both polarities
    for (int p = 0; p <= 6; p++) begin
      measure("R2 R5 pol1", p, 1, 64 + 20 * p, p);
      if (p == 6)
        measure("R3 code7 pol0", p, 0, 100, 7);
      else
        measure("R2 R5 pol0", p, 0, 30 + 25 * p, p);
    end

    // R4: duty boundaries 0 and 255, and R1 ignored bits
    measure("R4 duty255", 0, 1, 255, 0);
    wr(0, 16'hEE | (0 << 8));
    wr(2, 1);
    wait_run(1);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R4 duty0 with R1 junk bits", hi, 256 - 0 - 256 + 256);
    wr(3, 1);
    wait_run(0);

    // R9: mid-period change waits for the wrap
    wr(0, (64 << 8) | 16);
    wr(2, 1);
    wait_run(1);
    repeat (100) @(negedge clk);
    wr(0, (192 << 8) | 16);
    repeat (50) @(negedge clk);
    check("R9 old compare kept", pwm_out, 0);
    seen = 0;
    for (int i = 0; i < 300 && !pwm_out; i++) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R9 new compare after wrap", hi, 192);
    wr(3, 1);
    wait_run(0);

    // R6: slow clock, one tick every fourth cycle
    wr(1, 0);
    wr(0, (64 << 8) | 16);
    wr(2, 1);
    wait_run(1);
    hi = 0;
    for (int i = 0; i < 1024; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R6 slow clock high time", hi, 256);
    wr(3, 1);
    wait_run(0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule